// File: doc/BRIEF.md
# GPIO Output Register Block with Atomic Mask Aliases

This block is a memory-mapped slave that owns the output-level and output-enable state of a bank of pins. Several bus requesters share it; two is the default, and they stand in for two processor cores. Each requester has its own single-cycle request port with a byte address, a 32-bit write word and a registered read response.

Software can load either state register with a plain whole-word write. It can also change selected bits with one store to a write-only alias: one alias sets the masked bits, one clears them and one toggles them. The update happens inside the block in the cycle of the write, so no requester ever reads, modifies and writes back. A write from the other requester cannot fall between a read and a write-back and be lost.

The block also returns synchronised pin input levels for the main bank and for a small high bank. It returns the index of the requester that asks, so code can tell which core it runs on. When requesters hit the same state register in the same cycle, the block merges their effects in a fixed order.

Top module: `gpio_alias_regs`

## Requirements
- R1: While rst_ni is low, pin_out_o, pin_oe_o and rvalid_o are all zero.
- R2: A write to byte address 0x010 loads the whole output-level register, and a write to 0x020 loads the whole output-enable register. The new value appears on the pins one clock after the write is sampled and is returned by later reads of the same address.
- R3: A write to 0x014 (level) or 0x024 (enable) ORs the written mask into that register, and leaves bits whose mask bit is zero unchanged.
- R4: A write to 0x018 (level) or 0x028 (enable) clears every bit whose mask bit is one, and leaves the others unchanged.
- R5: A write to 0x01C (level) or 0x02C (enable) inverts every bit whose mask bit is one, and leaves the others unchanged.
- R6: When several requesters write alias addresses of the same register in one cycle, the new value is ((old OR all set masks) AND NOT all clear masks) XOR every toggle mask. A bit toggled by both requesters therefore ends unchanged. Writes to different registers in one cycle all take effect.
- R7: A whole-word write to a register in a cycle overrides every alias write to that register in that cycle. When two requesters write the same register whole, the lower-indexed requester's value is kept.
- R8: A read of 0x000 returns the index of the requesting requester (0 or 1), even when both read in the same cycle.
- R9: A read of 0x004 returns the main-bank pin levels, and a read of 0x008 returns the high-bank levels zero-extended. Both pass through two flops. After a level change, reads sampled on the first and second rising edges still return the old value, and reads sampled on the third rising edge or later return the new value.
- R10: Reads of the alias addresses, the reserved word 0x00C, addresses at or above 0x030, and addresses with nonzero bits [1:0] return zero. Writes to 0x000 through 0x00C, to addresses at or above 0x030, or to addresses with nonzero bits [1:0] leave both registers unchanged.
- R11: A read request sampled on a rising edge raises that requester's rvalid_o for exactly the following cycle, and rdata_o carries the data. The data is the register value from before any write sampled on the same edge.
- R12: In any cycle with no write request, pin_out_o and pin_oe_o hold their values. Reads never change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_REQ | Per-requester request strobe, one cycle per access |
| we_i | input | NUM_REQ | Per-requester write select (1 write, 0 read) |
| addr_i | input | NUM_REQ*ADDR_W | Per-requester byte address, requester k at bits [k*ADDR_W +: ADDR_W] |
| wdata_i | input | NUM_REQ*DATA_W | Per-requester write word or mask |
| rvalid_o | output | NUM_REQ | Per-requester read response valid |
| rdata_o | output | NUM_REQ*DATA_W | Per-requester read data |
| pin_in_i | input | N_PINS | Asynchronous main-bank pin levels |
| pin_hi_in_i | input | HI_W | Asynchronous high-bank pin levels |
| pin_out_o | output | N_PINS | Output-level register |
| pin_oe_o | output | N_PINS | Output-enable register |

## Verification
On every cycle the bound assertions check several properties. The reset values hold while reset is low. Idle cycles leave both registers unchanged. A lone set or clear alias write leaves the masked bits high or low, and a lone toggle inverts exactly the masked bits. A whole-word write from requester 0 always wins. Every read draws a response in the next cycle, and the identity word always matches the asking requester. Only the directed scenarios can show the rest: how simultaneous alias writes merge, which value wins when both requesters write the register whole, the three-edge latency of the input synchroniser, zero reads and ignored writes at unmapped or misaligned addresses, and that a read returns the value from before a write made in the same cycle.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;

  // word index inside the 64-byte window; the index order is the software map
  localparam logic [3:0] W_ID      = 4'd0;
  localparam logic [3:0] W_IN      = 4'd1;
  localparam logic [3:0] W_HI      = 4'd2;
  localparam logic [3:0] W_RSV     = 4'd3;
  localparam logic [3:0] W_OUT     = 4'd4;
  localparam logic [3:0] W_OUT_SET = 4'd5;
  localparam logic [3:0] W_OUT_CLR = 4'd6;
  localparam logic [3:0] W_OUT_TGL = 4'd7;
  localparam logic [3:0] W_OE      = 4'd8;
  localparam logic [3:0] W_OE_SET  = 4'd9;
  localparam logic [3:0] W_OE_CLR  = 4'd10;
  localparam logic [3:0] W_OE_TGL  = 4'd11;

  typedef struct packed {
    logic wr;   // whole-word load
    logic set;
    logic clr;
    logic tgl;
  } alias_op_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_req_decode.sv
module gpio_req_decode
  import gpio_alias_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output alias_op_t         out_op_o,
  output alias_op_t         oe_op_o,
  output logic              rd_o,
  output logic [3:0]        rd_word_o
);
  logic       hit, wr;
  logic [3:0] widx;

  always_comb begin
    hit      = (addr_i[ADDR_W-1:6] == '0) && (addr_i[1:0] == 2'b00);
    widx     = addr_i[5:2];
    wr       = req_i && we_i && hit;
    out_op_o = '0;
    oe_op_o  = '0;
    case (widx)
      W_OUT:     out_op_o.wr  = wr;
      W_OUT_SET: out_op_o.set = wr;
      W_OUT_CLR: out_op_o.clr = wr;
      W_OUT_TGL: out_op_o.tgl = wr;
      W_OE:      oe_op_o.wr   = wr;
      W_OE_SET:  oe_op_o.set  = wr;
      W_OE_CLR:  oe_op_o.clr  = wr;
      W_OE_TGL:  oe_op_o.tgl  = wr;
      default: ;
    endcase
    rd_o      = req_i && !we_i;
    // misses read as the reserved word, which is zero
    rd_word_o = hit ? widx : W_RSV;
  end
endmodule

// File: rtl/gpio_reg_update.sv
module gpio_reg_update
  import gpio_alias_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned NUM_REQ = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  alias_op_t [NUM_REQ-1:0] op_i,
  input  logic [NUM_REQ*W-1:0]   mask_i,
  output logic [W-1:0]           q_o
);
  logic [W-1:0] q_r, q_d;
  logic [W-1:0] load_val, set_m, clr_m, tgl_m;
  logic         load;

  always_comb begin
    load     = 1'b0;
    load_val = '0;
    set_m    = '0;
    clr_m    = '0;
    tgl_m    = '0;
    // descending walk: lowest index whole-word write is taken last and wins
    for (int k = NUM_REQ - 1; k >= 0; k--) begin
      if (op_i[k].wr) begin
        load     = 1'b1;
        load_val = mask_i[k*W +: W];
      end
      if (op_i[k].set) set_m = set_m | mask_i[k*W +: W];
      if (op_i[k].clr) clr_m = clr_m | mask_i[k*W +: W];
      if (op_i[k].tgl) tgl_m = tgl_m ^ mask_i[k*W +: W];
    end
    q_d = load ? load_val : (((q_r | set_m) & ~clr_m) ^ tgl_m);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= '0;
    else         q_r <= q_d;
  end

  assign q_o = q_r;
endmodule

// File: rtl/gpio_alias_regs.sv
module gpio_alias_regs
  import gpio_alias_pkg::*;
#(
  parameter int unsigned NUM_REQ = 2,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_PINS  = 32,
  parameter int unsigned HI_W    = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_REQ-1:0]        req_i,
  input  logic [NUM_REQ-1:0]        we_i,
  input  logic [NUM_REQ*ADDR_W-1:0] addr_i,
  input  logic [NUM_REQ*DATA_W-1:0] wdata_i,
  output logic [NUM_REQ-1:0]        rvalid_o,
  output logic [NUM_REQ*DATA_W-1:0] rdata_o,
  input  logic [N_PINS-1:0]         pin_in_i,
  input  logic [HI_W-1:0]           pin_hi_in_i,
  output logic [N_PINS-1:0]         pin_out_o,
  output logic [N_PINS-1:0]         pin_oe_o
);
  localparam int unsigned MASK_W = NUM_REQ * N_PINS;

  alias_op_t [NUM_REQ-1:0] out_ops, oe_ops;
  logic [MASK_W-1:0]       wmask;
  logic [N_PINS-1:0]       in_sync, out_q, oe_q;
  logic [HI_W-1:0]         hi_sync;

  gpio_sync #(.W(N_PINS)) u_sync_in (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_in_i), .q_o(in_sync)
  );

  gpio_sync #(.W(HI_W)) u_sync_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_hi_in_i), .q_o(hi_sync)
  );

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_req
    alias_op_t          out_op, oe_op;
    logic               rd;
    logic [3:0]         rd_word;
    logic [DATA_W-1:0]  rd_mux, rdata_q;
    logic               rvalid_q;

    gpio_req_decode #(.ADDR_W(ADDR_W)) u_dec (
      .req_i    (req_i[k]),
      .we_i     (we_i[k]),
      .addr_i   (addr_i[k*ADDR_W +: ADDR_W]),
      .out_op_o (out_op),
      .oe_op_o  (oe_op),
      .rd_o     (rd),
      .rd_word_o(rd_word)
    );

    assign out_ops[k]                = out_op;
    assign oe_ops[k]                 = oe_op;
    assign wmask[k*N_PINS +: N_PINS] = wdata_i[k*DATA_W +: N_PINS];

    always_comb begin
      rd_mux = '0;
      case (rd_word)
        W_ID:  rd_mux = DATA_W'(k);
        W_IN:  rd_mux[N_PINS-1:0] = in_sync;
        W_HI:  rd_mux[HI_W-1:0]   = hi_sync;
        W_OUT: rd_mux[N_PINS-1:0] = out_q;
        W_OE:  rd_mux[N_PINS-1:0] = oe_q;
        default: ;
      endcase
    end

    // sampled from pre-write state: reads see the old value on a same-edge write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rvalid_q <= 1'b0;
        rdata_q  <= '0;
      end else begin
        rvalid_q <= rd;
        if (rd) rdata_q <= rd_mux;
      end
    end

    assign rvalid_o[k]                = rvalid_q;
    assign rdata_o[k*DATA_W +: DATA_W] = rdata_q;
  end

  gpio_reg_update #(.W(N_PINS), .NUM_REQ(NUM_REQ)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(out_ops), .mask_i(wmask), .q_o(out_q)
  );

  gpio_reg_update #(.W(N_PINS), .NUM_REQ(NUM_REQ)) u_oe (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(oe_ops), .mask_i(wmask), .q_o(oe_q)
  );

  assign pin_out_o = out_q;
  assign pin_oe_o  = oe_q;
endmodule

// File: rtl/gpio_alias_regs_chk.sv
module gpio_alias_regs_chk #(
  parameter int unsigned NUM_REQ = 2,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_PINS  = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_REQ-1:0]        req_i,
  input logic [NUM_REQ-1:0]        we_i,
  input logic [NUM_REQ*ADDR_W-1:0] addr_i,
  input logic [NUM_REQ*DATA_W-1:0] wdata_i,
  input logic [NUM_REQ-1:0]        rvalid_o,
  input logic [NUM_REQ*DATA_W-1:0] rdata_o,
  input logic [N_PINS-1:0]         pin_out_o,
  input logic [N_PINS-1:0]         pin_oe_o
);
  logic [NUM_REQ-1:0] wr_req;
  assign wr_req = req_i & we_i;

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (pin_out_o == '0 && pin_oe_o == '0 && rvalid_o == '0);
    end
  end

  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req == '0) |=> ($stable(pin_out_o) && $stable(pin_oe_o)));

  // R7
  direct_r0_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req[0] && addr_i[ADDR_W-1:0] == ADDR_W'('h10))
      |=> (pin_out_o == $past(wdata_i[N_PINS-1:0])));

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_chk
    logic [ADDR_W-1:0] a;
    logic [N_PINS-1:0] m;
    logic              solo;
    assign a    = addr_i[k*ADDR_W +: ADDR_W];
    assign m    = wdata_i[k*DATA_W +: N_PINS];
    assign solo = (wr_req == (NUM_REQ'(1) << k));

    // R11
    rd_response_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (rvalid_o[k] == $past(req_i[k] && !we_i[k])));

    // R8
    id_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[k] && !we_i[k] && a == '0) |=> (rdata_o[k*DATA_W +: DATA_W] == DATA_W'(k)));

    // R3
    set_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (solo && a == ADDR_W'('h14)) |=> ((pin_out_o & $past(m)) == $past(m)));

    // R4
    clr_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (solo && a == ADDR_W'('h28)) |=> ((pin_oe_o & $past(m)) == '0));

    // R5
    tgl_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (solo && a == ADDR_W'('h1C)) |=> (pin_out_o == ($past(pin_out_o) ^ $past(m))));
  end
endmodule

bind gpio_alias_regs gpio_alias_regs_chk #(
  .NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PINS(N_PINS)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rvalid_o (rvalid_o),
  .rdata_o  (rdata_o),
  .pin_out_o(pin_out_o),
  .pin_oe_o (pin_oe_o)
);

// File: tb/gpio_alias_regs_tb.sv
module gpio_alias_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  req_i = '0;
  logic [1:0]  we_i = '0;
  logic [23:0] addr_i = '0;
  logic [63:0] wdata_i = '0;
  logic [1:0]  rvalid_o;
  logic [63:0] rdata_o;
  logic [31:0] pin_in_i = '0;
  logic [5:0]  pin_hi_in_i = '0;
  logic [31:0] pin_out_o, pin_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_alias_regs dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
    .pin_in_i(pin_in_i), .pin_hi_in_i(pin_hi_in_i),
    .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [1:0] r, input logic [1:0] w,
                      input logic [11:0] a0, input logic [31:0] d0,
                      input logic [11:0] a1, input logic [31:0] d1);
    req_i = r; we_i = w; addr_i = {a1, a0}; wdata_i = {d1, d0};
    @(posedge clk_i);
    #1;
    req_i = '0; we_i = '0;
  endtask

  task automatic wr0(input logic [11:0] a, input logic [31:0] d);
    xfer(2'b01, 2'b01, a, d, 12'h0, 32'h0);
  endtask

  task automatic rd(input int k, input logic [11:0] a, output logic [31:0] d);
    if (k == 0) xfer(2'b01, 2'b00, a, 32'h0, 12'h0, 32'h0);
    else        xfer(2'b10, 2'b00, 12'h0, 32'h0, a, 32'h0);
    chk("R11 rvalid", 32'(rvalid_o[k]), 32'h1);
    d = rdata_o[k*32 +: 32];
  endtask

  task automatic t_reset();
    chk("R1 out", pin_out_o, 32'h0);
    chk("R1 oe", pin_oe_o, 32'h0);
    chk("R1 rvalid", 32'(rvalid_o), 32'h0);
  endtask

  task automatic t_direct();
    logic [31:0] d;
    wr0(12'h010, 32'hA5A5_0F0F);
    chk("R2 out load", pin_out_o, 32'hA5A5_0F0F);
    xfer(2'b10, 2'b10, 12'h0, 32'h0, 12'h020, 32'h0000_FFFF);
    chk("R2 oe load", pin_oe_o, 32'h0000_FFFF);
    rd(1, 12'h010, d);
    chk("R2 out readback", d, 32'hA5A5_0F0F);
    rd(0, 12'h020, d);
    chk("R2 oe readback", d, 32'h0000_FFFF);
  endtask

  task automatic t_set();
    wr0(12'h010, 32'h0000_00F0);
    wr0(12'h014, 32'h0F00_000F);
    chk("R3 out set", pin_out_o, 32'h0F00_00FF);
    wr0(12'h020, 32'h0000_0001);
    xfer(2'b10, 2'b10, 12'h0, 32'h0, 12'h024, 32'h8000_0000);
    chk("R3 oe set", pin_oe_o, 32'h8000_0001);
  endtask

  task automatic t_clr();
    wr0(12'h018, 32'h0F00_00F0);
    chk("R4 out clr", pin_out_o, 32'h0000_000F);
    wr0(12'h028, 32'h0000_0003);
    chk("R4 oe clr", pin_oe_o, 32'h8000_0000);
  endtask

  task automatic t_xor();
    wr0(12'h01C, 32'hF000_0003);
    chk("R5 out xor", pin_out_o, 32'hF000_000C);
    wr0(12'h02C, 32'hC000_0000);
    chk("R5 oe xor", pin_oe_o, 32'h4000_0000);
  endtask

  task automatic t_concurrent();
    wr0(12'h010, 32'h0);
    xfer(2'b11, 2'b11, 12'h014, 32'h0000_00FF, 12'h018, 32'h0000_000F);
    chk("R6 set then clr", pin_out_o, 32'h0000_00F0);
    xfer(2'b11, 2'b11, 12'h01C, 32'h0000_FF00, 12'h01C, 32'h0000_0F00);
    chk("R6 double xor", pin_out_o, 32'h0000_F0F0);
    xfer(2'b11, 2'b11, 12'h01C, 32'h0000_0001, 12'h014, 32'h0000_0003);
    chk("R6 set then xor", pin_out_o, 32'h0000_F0F2);
    wr0(12'h020, 32'h0);
    xfer(2'b11, 2'b11, 12'h024, 32'h0000_0011, 12'h018, 32'h0000_00F0);
    chk("R6 split oe", pin_oe_o, 32'h0000_0011);
    chk("R6 split out", pin_out_o, 32'h0000_F002);
  endtask

  task automatic t_priority();
    xfer(2'b11, 2'b11, 12'h010, 32'h1234_5678, 12'h014, 32'hFFFF_FFFF);
    chk("R7 r0 load over set", pin_out_o, 32'h1234_5678);
    xfer(2'b11, 2'b11, 12'h018, 32'hFFFF_FFFF, 12'h010, 32'h0BAD_0000);
    chk("R7 r1 load over clr", pin_out_o, 32'h0BAD_0000);
    xfer(2'b11, 2'b11, 12'h020, 32'h0000_1111, 12'h020, 32'h0000_2222);
    chk("R7 both load", pin_oe_o, 32'h0000_1111);
  endtask

  task automatic t_id();
    logic [31:0] d;
    rd(0, 12'h000, d);
    chk("R8 id r0", d, 32'h0);
    rd(1, 12'h000, d);
    chk("R8 id r1", d, 32'h1);
    xfer(2'b11, 2'b00, 12'h000, 32'h0, 12'h000, 32'h0);
    chk("R8 both rvalid", 32'(rvalid_o), 32'h3);
    chk("R8 both r0", rdata_o[31:0], 32'h0);
    chk("R8 both r1", rdata_o[63:32], 32'h1);
  endtask

  task automatic t_sync();
    logic [31:0] d;
    pin_in_i = 32'hDEAD_BEEF;
    rd(0, 12'h004, d);
    chk("R9 edge1 old", d, 32'h0);
    rd(0, 12'h004, d);
    chk("R9 edge2 old", d, 32'h0);
    rd(0, 12'h004, d);
    chk("R9 edge3 new", d, 32'hDEAD_BEEF);
    pin_hi_in_i = 6'h2A;
    rd(1, 12'h008, d);
    chk("R9 hi edge1 old", d, 32'h0);
    rd(1, 12'h008, d);
    rd(1, 12'h008, d);
    chk("R9 hi edge3 new", d, 32'h0000_002A);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    logic [11:0] wa [8] = '{12'h000, 12'h004, 12'h008, 12'h00C,
                            12'h030, 12'h03C, 12'h040, 12'h011};
    logic [11:0] ra [9] = '{12'h014, 12'h018, 12'h01C, 12'h024,
                            12'h028, 12'h02C, 12'h00C, 12'h030, 12'h012};
    wr0(12'h010, 32'h0000_0055);
    wr0(12'h020, 32'h0000_00AA);
    for (int i = 0; i < 8; i++) begin
      xfer(2'b11, 2'b11, wa[i], 32'hFFFF_FFFF, wa[i], 32'h0);
      chk("R10 write ignored out", pin_out_o, 32'h0000_0055);
      chk("R10 write ignored oe", pin_oe_o, 32'h0000_00AA);
    end
    for (int i = 0; i < 9; i++) begin
      rd(i % 2, ra[i], d);
      chk("R10 read zero", d, 32'h0);
    end
  endtask

  task automatic t_order();
    wr0(12'h010, 32'h0000_0001);
    xfer(2'b11, 2'b10, 12'h010, 32'h0, 12'h010, 32'h0000_0002);
    chk("R11 read-before-write data", rdata_o[31:0], 32'h0000_0001);
    chk("R11 rvalid only reader", 32'(rvalid_o), 32'h1);
    chk("R11 write landed", pin_out_o, 32'h0000_0002);
    @(posedge clk_i);
    #1;
    chk("R11 rvalid drops", 32'(rvalid_o), 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_i);
      #1;
    end
    chk("R12 idle out", pin_out_o, 32'h0000_0002);
    rd(1, 12'h010, d);
    rd(0, 12'h020, d);
    chk("R12 read no effect out", pin_out_o, 32'h0000_0002);
    chk("R12 read no effect oe", pin_oe_o, 32'h0000_00AA);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    t_direct();
    t_set();
    t_clr();
    t_xor();
    t_concurrent();
    t_priority();
    t_id();
    t_sync();
    t_ignored();
    t_order();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule